// File: doc/BRIEF.md
# Narrowband Reverse-Channel Frame Formatter

This block turns one 36-bit message word into a complete narrowband reverse voice channel data frame. The frame leaves on a single serial output that advances once per 200 Hz bit tick. A frame has four parts. First comes a 24-bit signaling-tone field. Next is a fixed 30-bit sync word. Then the 48-bit BCH codeword follows, Manchester coded. A second 24-bit signaling-tone field closes the frame. The codeword holds the 36 message bits and then 12 parity bits. The parity is computed serially while the message bits are being sent.

The signaling-tone bits are not stored in the block. They are read live from a 24-bit input, most significant bit first, while each tone field is being sent. An external tone generator therefore keeps control of which tone pattern is on the line. A one-cycle start pulse loads the message word. A busy output stays high for the whole frame, and a one-cycle done pulse marks its end. The frame advances only on clock cycles where the tick enable is high, so the system clock can be much faster than the bit rate.

Top module: `rvc_frame_fmt`

## Requirements
- R1: After reset, and at any time no frame is in progress, `busy`, `done` and `tx_bit` are all 0.
- R2: A `start` pulse while idle loads `msg_word`. From the next cycle `busy` is 1 and `tx_bit` shows the first bit of the leading tone field.
- R3: The frame is 174 positions long: 24 leading tone, 30 sync, 96 codeword half-bits and 24 trailing tone. It moves one position per cycle in which `tick` is 1, and it holds its position in cycles where `tick` is 0.
- R4: The sync field is the 30-bit pattern 011001010110101001100110100110, sent left to right.
- R5: In both tone fields, position k (0 to 23) carries `tone_word[23-k]`, read at the time that position is on the line.
- R6: Codeword bit j for j below 36 is `msg_word[35-j]` as loaded at start, so the most significant bit goes first.
- R7: Codeword bits 36 to 47 are the remainder of (message × x^12) divided by x^12+x^10+x^8+x^5+x^4+x^3+1, sent from the most significant bit down. The low 12 bits of the generator are 0x539. An all-zero message gives zero parity, and a message of 1 gives parity 0x539.
- R8: Each codeword bit takes two positions. A 1 is sent as 1 then 0, and a 0 is sent as 0 then 1.
- R9: On the tick that ends the last trailing tone position, `done` is 1 for exactly one cycle and `busy` drops to 0 in that same cycle.
- R10: A `start` pulse while `busy` is 1 is ignored. The frame in progress keeps its loaded message and its position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 200 Hz bit-rate enable, one clock wide |
| start | input | 1 | Begin a frame (honoured only when idle) |
| msg_word | input | 36 | Message word, loaded on an accepted start |
| tone_word | input | 24 | Current signaling-tone pattern, read live in tone fields |
| tx_bit | output | 1 | Serial frame output |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Suppose the position counter is wrong or a field boundary is off by one. The very next tick then puts a tone, sync or codeword bit at the wrong place on `tx_bit`, and the length of `busy` no longer comes to 174 ticks. The parity register cannot be seen directly. Once it goes bad, the error appears only when the first parity half-bit goes out, 36 codeword bits after the fault at the latest. That is why the bench compares every position of every frame. It uses messages whose parity is known (all zeros, a single 1, all ones) and also mixed messages. Tick spacing is stretched so that a hold failure shows up within one clock.

// File: rtl/rvc_fmt_pkg.sv
package rvc_fmt_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_SYNC  = 3'd2,
    PH_DATA  = 3'd3,
    PH_TRAIL = 3'd4
  } phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/rvc_fmt_seq.sv
module rvc_fmt_seq
  import rvc_fmt_pkg::*;
#(
  parameter int TONE_W = 24,
  parameter int SYNC_W = 30,
  parameter int HALF_N = 96,
  parameter int CNT_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  output phase_e           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             busy,
  output logic             done,
  output logic             launch
);
  localparam logic [CNT_W-1:0] TONE_LAST = CNT_W'(TONE_W - 1);
  localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(HALF_N - 1);

  phase_e           phase_n;
  logic [CNT_W-1:0] cnt_n;
  logic             done_n;

  always_comb begin
    phase_n = phase;
    cnt_n   = cnt;
    done_n  = 1'b0;
    unique case (phase)
      PH_IDLE: if (start) begin
        phase_n = PH_LEAD;
        cnt_n   = '0;
      end
      PH_LEAD: if (tick) begin
        if (cnt == TONE_LAST) begin phase_n = PH_SYNC; cnt_n = '0; end
        else cnt_n = cnt + 1'b1;
      end
      PH_SYNC: if (tick) begin
        if (cnt == SYNC_LAST) begin phase_n = PH_DATA; cnt_n = '0; end
        else cnt_n = cnt + 1'b1;
      end
      PH_DATA: if (tick) begin
        if (cnt == DATA_LAST) begin phase_n = PH_TRAIL; cnt_n = '0; end
        else cnt_n = cnt + 1'b1;
      end
      PH_TRAIL: if (tick) begin
        if (cnt == TONE_LAST) begin
          phase_n = PH_IDLE;
          cnt_n   = '0;
          done_n  = 1'b1;
        end else cnt_n = cnt + 1'b1;
      end
      default: begin
        phase_n = PH_IDLE;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      phase <= phase_n;
      cnt   <= cnt_n;
      done  <= done_n;
    end
  end

  assign busy   = (phase != PH_IDLE);
  assign launch = (phase == PH_IDLE) && start;
endmodule

// File: rtl/rvc_fmt_bch.sv
module rvc_fmt_bch #(
  parameter int              PAR_W = 12,
  parameter logic [PAR_W-1:0] POLY = 12'h539
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic shift,
  input  logic absorb,
  input  logic din,
  output logic msb
);
  logic [PAR_W-1:0] rem_q;
  logic [PAR_W-1:0] rem_n;
  logic             fb;

  always_comb begin
    fb    = rem_q[PAR_W-1] ^ din;
    rem_n = rem_q;
    if (clr)
      rem_n = '0;
    else if (shift) begin
      if (absorb)
        rem_n = {rem_q[PAR_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      else
        rem_n = {rem_q[PAR_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_n;
  end

  assign msb = rem_q[PAR_W-1];
endmodule

// File: rtl/rvc_frame_fmt.sv
module rvc_frame_fmt
  import rvc_fmt_pkg::*;
#(
  parameter int                 TONE_W   = 24,
  parameter int                 SYNC_W   = 30,
  parameter int                 INFO_W   = 36,
  parameter int                 PAR_W    = 12,
  parameter logic [PAR_W-1:0]   POLY     = 12'h539,
  parameter logic [SYNC_W-1:0]  SYNC_PAT = 30'b011001010110101001100110100110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [INFO_W-1:0] msg_word,
  input  logic [TONE_W-1:0] tone_word,
  output logic              tx_bit,
  output logic              busy,
  output logic              done
);
  localparam int CW_W   = INFO_W + PAR_W;
  localparam int HALF_N = 2 * CW_W;
  localparam int CNT_W  = $clog2(max3(TONE_W, SYNC_W, HALF_N));

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  phase_e             phase;
  logic [CNT_W-1:0]   cnt;
  logic               launch;
  logic [INFO_W-1:0]  msg_q;
  logic [CNT_W-2:0]   bit_idx;
  logic               half;
  logic               info;
  logic               msg_bit, tone_bit, sync_bit, par_msb, code_bit;

  rvc_fmt_seq #(
    .TONE_W(TONE_W), .SYNC_W(SYNC_W), .HALF_N(HALF_N), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .start(start),
    .phase(phase), .cnt(cnt), .busy(busy), .done(done), .launch(launch)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  msg_q <= '0;
    else if (launch)  msg_q <= msg_word;
  end

  assign bit_idx = cnt[CNT_W-1:1];
  assign half    = cnt[0];
  assign info    = (int'(bit_idx) < INFO_W);

  always_comb begin
    msg_bit = 1'b0;
    for (int i = 0; i < INFO_W; i++)
      if (int'(bit_idx) == i) msg_bit = msg_q[INFO_W-1-i];
  end

  always_comb begin
    tone_bit = 1'b0;
    for (int i = 0; i < TONE_W; i++)
      if (int'(cnt) == i) tone_bit = tone_word[TONE_W-1-i];
  end

  always_comb begin
    sync_bit = 1'b0;
    for (int i = 0; i < SYNC_W; i++)
      if (int'(cnt) == i) sync_bit = SYNC_PAT[SYNC_W-1-i];
  end

  rvc_fmt_bch #(.PAR_W(PAR_W), .POLY(POLY)) u_bch (
    .clk(clk), .rst_n(rst_sync_n),
    .clr(launch),
    .shift((phase == PH_DATA) && tick && half),
    .absorb(info),
    .din(msg_bit),
    .msb(par_msb)
  );

  assign code_bit = info ? msg_bit : par_msb;

  always_comb begin
    unique case (phase)
      PH_LEAD, PH_TRAIL: tx_bit = tone_bit;
      PH_SYNC:           tx_bit = sync_bit;
      PH_DATA:           tx_bit = half ? ~code_bit : code_bit;
      default:           tx_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/rvc_fmt_chk.sv
module rvc_fmt_chk
  import rvc_fmt_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int INFO_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              tx_bit,
  input phase_e            phase,
  input logic [CNT_W-1:0]  cnt,
  input logic [INFO_W-1:0] msg_q
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_bit);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R3
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> ($stable(cnt) && $stable(phase)));

  // R8
  manch_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && !cnt[0] && tick) |=> (tx_bit != $past(tx_bit)));

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(msg_q));
endmodule

bind rvc_frame_fmt rvc_fmt_chk #(.CNT_W(CNT_W), .INFO_W(INFO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .busy(busy),
  .done(done), .tx_bit(tx_bit), .phase(phase), .cnt(cnt), .msg_q(msg_q)
);

// File: tb/rvc_frame_fmt_test.sv
module rvc_frame_fmt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        start = 1'b0;
  logic [35:0] msg_word = '0;
  logic [23:0] tone_word = '0;
  logic        tx_bit, busy, done;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // reference model state
  bit m_busy = 0;
  bit m_done = 0;
  int m_pos  = 0;
  bit frame_q[$];
  string scen = "";

  always #10 clk = ~clk;

  rvc_frame_fmt uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .msg_word(msg_word), .tone_word(tone_word),
    .tx_bit(tx_bit), .busy(busy), .done(done)
  );

  function automatic logic [11:0] ref_parity(input logic [35:0] m);
    logic [47:0] r;
    r = {m, 12'h000};
    for (int k = 47; k >= 12; k--)
      if (r[k]) r = r ^ (48'h1539 << (k - 12));
    return r[11:0];
  endfunction

  function automatic string pos_req(input int p);
    if (p < 24 || p >= 150) return "R5";
    if (p < 54)             return "R4";
    if ((p - 54) / 2 < 36)  return "R6/R8";
    return "R7/R8";
  endfunction

  task automatic build_frame(input logic [35:0] m, input logic [23:0] t);
    logic [47:0] cw;
    logic [29:0] syn;
    syn = 30'b011001010110101001100110100110;
    cw  = {m, ref_parity(m)};
    frame_q.delete();
    for (int i = 23; i >= 0; i--) frame_q.push_back(t[i]);
    for (int i = 29; i >= 0; i--) frame_q.push_back(syn[i]);
    for (int i = 47; i >= 0; i--) begin
      frame_q.push_back(cw[i]);
      frame_q.push_back(~cw[i]);
    end
    for (int i = 23; i >= 0; i--) frame_q.push_back(t[i]);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (pos %0d)", req, scen, act, exp, m_pos);
    end
  endtask

  task automatic compare();
    logic exp_tx;
    exp_tx = m_busy ? frame_q[m_pos] : 1'b0;
    check(m_busy ? pos_req(m_pos) : "R1", tx_bit, exp_tx);
    check("R2/R3", busy, m_busy);
    check("R9", done, m_done);
  endtask

  // one clock: compare at negedge, drive inputs, advance model
  task automatic cyc(input bit s, input bit t);
    @(negedge clk);
    compare();
    start = s;
    tick  = t;
    if (!m_busy && s) begin
      build_frame(msg_word, tone_word);
      m_busy = 1; m_pos = 0; m_done = 0;
    end else if (m_busy && t) begin
      if (m_pos == 173) begin m_busy = 0; m_done = 1; m_pos = 0; end
      else begin m_pos++; m_done = 0; end
    end else m_done = 0;
  endtask

  task automatic run_frame(input logic [35:0] m, input logic [23:0] t,
                           input int per, input int poke);
    int n;
    @(negedge clk);
    msg_word  = m;
    tone_word = t;
    cyc(1'b1, 1'b0);
    n = 0;
    while (m_busy) begin
      n++;
      if (poke > 0 && n == poke) begin
        msg_word = ~m;          // R10: must not be loaded
        cyc(1'b1, (n % per) == 0);
      end else
        cyc(1'b0, (n % per) == 0);
    end
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b1);            // idle tick: nothing moves (R1)
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    scen = "reset";
    check("R1", busy, 1'b0);
    check("R1", done, 1'b0);
    check("R1", tx_bit, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc(1'b0, 1'b1);

    scen = "zero msg, tick every clock (R7)";
    run_frame(36'h0, 24'h2556CB, 1, 0);
    scen = "msg=1 gives parity 0x539 (R7)";
    run_frame(36'h1, 24'hDAA934, 1, 0);
    scen = "all ones (R6 R8)";
    run_frame(36'hF_FFFF_FFFF, 24'h255B2B, 2, 0);
    scen = "sparse tick hold (R3)";
    run_frame(36'h9_A5C3_1E77, 24'hD954D4, 3, 0);
    scen = "start while busy (R10)";
    run_frame(36'h4_0123_8BCD, 24'h26B2AD, 1, 40);
    scen = "start while busy in data (R10)";
    run_frame(36'h8_0000_0001, 24'hD69654, 2, 200);
    scen = "back to back (R2)";
    run_frame(36'h5_5555_AAAA, 24'h2669AB, 1, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule